// File: doc/BRIEF.md
# Clock-Gated Moore State Machine

A four-state Moore controller whose state register is only updated in cycles where the state would actually change. A self-loop detector looks at the present state and the primary inputs. When it sees one of the two state/input pairs that lead back to the same state, it drops the update enable for that cycle. The enable passes through a level-sensitive latch that is transparent while the clock is low. Its output is the register's update enable, and it is also driven out as `gclk_en` so that tests can observe it.

The machine has four states. IDLE waits for `start` and loops on itself otherwise. ARM is a one-cycle pass-through state. RUN keeps running until `halt` and loops on itself otherwise. DRAIN either resumes RUN on `start` or falls back to IDLE. The outputs come from the state alone.

A counter reports how many cycles the register was frozen. Because a self-loop leaves the state unchanged, the gated machine must follow the same state and output sequence as an ungated machine, cycle for cycle, for any input stream.

Top module: `cg_moore_fsm`

## Requirements
- R1: `fsm_out` is a function of the state only: IDLE=00, ARM=01, RUN=11, DRAIN=10. An input change that does not change the state leaves `fsm_out` unchanged.
- R2: The transitions are as follows, with `in_vec[0]`=start and `in_vec[1]`=halt. IDLE goes to ARM on start and stays otherwise. ARM always goes to RUN. RUN goes to DRAIN on halt and stays otherwise. DRAIN goes to RUN on start and to IDLE otherwise.
- R3: Outside reset, `gclk_en` is 0 exactly for the pairs (IDLE, start=0) and (RUN, halt=0), and 1 for every other state/input pair.
- R4: In a cycle where the enable is 0, the state register keeps its value across the clock edge.
- R5: A synchronous `rst` puts the machine in IDLE and clears `gate_cnt`. During reset, `gclk_en` is 1 whatever the inputs are.
- R6: `gate_cnt` rises by one after each clock edge taken with the enable at 0, wraps modulo 2^CNT_W, and holds otherwise.
- R7: The enable is captured while the clock is low. An input change during the clock's high phase does not change `gclk_en` until the clock falls.
- R8: The state and output sequence equals that of an ungated machine with the same transitions, for any input stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vec | input | 2 | Primary inputs: bit 0 start, bit 1 halt |
| fsm_out | output | 2 | State-decoded Moore output |
| gclk_en | output | 1 | Latched update enable of the state register |
| gate_cnt | output | CNT_W | Count of frozen cycles, wrapping |

## Verification
On every cycle, the assertions check the following:
- a disabled update leaves the state and the outputs frozen;
- an enabled update always changes the state;
- ARM lasts exactly one cycle;
- the frozen-cycle counter steps or holds in line with the enable.

Only the bench's scenarios can show three further properties:
- that the enable falls for exactly the two self-loop pairs;
- that an input change in the high phase does not reach the enable before the clock falls;
- that the full output sequence, including reset in mid-run and counter wrap, matches an ungated reference.

// File: rtl/cg_fsm_pkg.sv
package cg_fsm_pkg;
    localparam int IN_W  = 2;
    localparam int OUT_W = 2;
    localparam int BIT_START = 0;
    localparam int BIT_HALT  = 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_RUN   = 2'd2,
        ST_DRAIN = 2'd3
    } fsm_state_t;

    localparam logic [OUT_W-1:0] OUT_IDLE  = 2'b00;
    localparam logic [OUT_W-1:0] OUT_ARM   = 2'b01;
    localparam logic [OUT_W-1:0] OUT_RUN   = 2'b11;
    localparam logic [OUT_W-1:0] OUT_DRAIN = 2'b10;
endpackage

// File: rtl/cg_fsm_next.sv
module cg_fsm_next
    import cg_fsm_pkg::*;
(
    input  fsm_state_t        cur_state,
    input  logic [IN_W-1:0]   in_vec,
    output fsm_state_t        nxt_state,
    output logic              self_loop
);
    logic start_i;
    logic halt_i;

    assign start_i = in_vec[BIT_START];
    assign halt_i  = in_vec[BIT_HALT];

    // next-state logic for the ungated machine
    always_comb begin
        nxt_state = cur_state;
        unique case (cur_state)
            ST_IDLE:  nxt_state = start_i ? ST_ARM : ST_IDLE;
            ST_ARM:   nxt_state = ST_RUN;
            ST_RUN:   nxt_state = halt_i ? ST_DRAIN : ST_RUN;
            ST_DRAIN: nxt_state = start_i ? ST_RUN : ST_IDLE;
            default:  nxt_state = ST_IDLE;
        endcase
    end

    // clock activation: decode the self-loop state/input pairs directly
    always_comb begin
        self_loop = 1'b0;
        unique case (cur_state)
            ST_IDLE:  self_loop = ~start_i;
            ST_RUN:   self_loop = ~halt_i;
            default:  self_loop = 1'b0;
        endcase
    end
endmodule

// File: rtl/cg_fsm_enlatch.sv
module cg_fsm_enlatch (
    input  logic clk,
    input  logic en_d,
    output logic en_q
);
    // transparent while the clock is low, held through the high phase
    always_latch begin
        if (!clk) begin
            en_q = en_d;
        end
    end
endmodule

// File: rtl/cg_fsm_outdec.sv
module cg_fsm_outdec
    import cg_fsm_pkg::*;
(
    input  fsm_state_t         cur_state,
    output logic [OUT_W-1:0]   fsm_out
);
    always_comb begin
        fsm_out = OUT_IDLE;
        unique case (cur_state)
            ST_IDLE:  fsm_out = OUT_IDLE;
            ST_ARM:   fsm_out = OUT_ARM;
            ST_RUN:   fsm_out = OUT_RUN;
            ST_DRAIN: fsm_out = OUT_DRAIN;
            default:  fsm_out = OUT_IDLE;
        endcase
    end
endmodule

// File: rtl/cg_moore_fsm.sv
module cg_moore_fsm
    import cg_fsm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [IN_W-1:0]     in_vec,
    output logic [OUT_W-1:0]    fsm_out,
    output logic                gclk_en,
    output logic [CNT_W-1:0]    gate_cnt
);
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    fsm_state_t state_q;
    fsm_state_t state_d;
    logic       self_loop;
    logic       upd_en_d;
    logic       upd_en;

    cg_fsm_next u_next (
        .cur_state (state_q),
        .in_vec    (in_vec),
        .nxt_state (state_d),
        .self_loop (self_loop)
    );

    // reset always opens the gate so the initial state can load
    assign upd_en_d = rst | ~self_loop;

    cg_fsm_enlatch u_lat (
        .clk  (clk),
        .en_d (upd_en_d),
        .en_q (upd_en)
    );

    // state register: loads only when the latched enable is open
    always_ff @(posedge clk) begin
        if (upd_en) begin
            state_q <= rst ? ST_IDLE : state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_cnt <= '0;
        end else if (!upd_en) begin
            gate_cnt <= gate_cnt + CNT_ONE;
        end
    end

    cg_fsm_outdec u_out (
        .cur_state (state_q),
        .fsm_out   (fsm_out)
    );

    assign gclk_en = upd_en;
endmodule

// File: rtl/cg_moore_fsm_chk.sv
module cg_moore_fsm_chk
    import cg_fsm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst,
    input fsm_state_t        state_q,
    input logic              upd_en,
    input logic [OUT_W-1:0]  fsm_out,
    input logic [CNT_W-1:0]  gate_cnt
);
    localparam logic [CNT_W-1:0] ONE_C = {{(CNT_W-1){1'b0}}, 1'b1};

    // R4
    hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> $stable(state_q));

    // R1
    out_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> $stable(fsm_out));

    // R3
    open_moves_chk: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> !$stable(state_q));

    // R2
    arm_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ARM) |=> (state_q == ST_RUN));

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> (gate_cnt == $past(gate_cnt) + ONE_C));

    // R6
    cnt_keep_chk: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> $stable(gate_cnt));
endmodule

bind cg_moore_fsm cg_moore_fsm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .state_q  (state_q),
    .upd_en   (upd_en),
    .fsm_out  (fsm_out),
    .gate_cnt (gate_cnt)
);

// File: tb/cg_moore_fsm_tb_top.sv
module cg_moore_fsm_tb_top;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    in_vec = 2'b00;
    logic [1:0]    fsm_out;
    logic          gclk_en;
    logic [CW-1:0] gate_cnt;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct { logic [1:0] out; logic [CW-1:0] cnt; } exp_t;
    exp_t sb_q[$];

    // reference model: 0 IDLE, 1 ARM, 2 RUN, 3 DRAIN (ungated)
    int            m_st  = 0;
    logic [CW-1:0] m_cnt = '0;

    cg_moore_fsm #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .in_vec(in_vec),
        .fsm_out(fsm_out), .gclk_en(gclk_en), .gate_cnt(gate_cnt)
    );

    always #5 clk = ~clk;

    function automatic logic [1:0] out_of(int s);
        case (s)
            0: return 2'b00;
            1: return 2'b01;
            2: return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver: one cycle of stimulus, expectations pushed to the scoreboard
    task automatic step(bit r, bit st, bit ht);
        bit hold;
        exp_t e;
        @(negedge clk);
        rst = r;
        in_vec = {ht, st};
        hold = !r && ((m_st == 0 && !st) || (m_st == 2 && !ht));
        #1;
        // R3 R5: enable follows the self-loop pairs, open during reset
        check(gclk_en == !hold, "R3/R5 gclk_en", gclk_en, !hold);
        if (r) begin
            m_st = 0;
            m_cnt = '0;
        end else begin
            if (hold) m_cnt = m_cnt + 1'b1;
            case (m_st)
                0: m_st = st ? 1 : 0;
                1: m_st = 2;
                2: m_st = ht ? 3 : 2;
                default: m_st = st ? 2 : 0;
            endcase
        end
        e.out = out_of(m_st);
        e.cnt = m_cnt;
        sb_q.push_back(e);
    endtask

    // monitor: compares after each clock edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                // R1 R2 R4 R8: output sequence equals ungated reference
                check(fsm_out == e.out, "R1/R2/R4/R8 fsm_out", fsm_out, e.out);
                // R6: frozen-cycle counter
                check(gate_cnt == e.cnt, "R6 gate_cnt", gate_cnt, e.cnt);
            end
        end
    end

    initial begin
        step(1, 1, 1);
        step(1, 0, 0);
        // R5: reset state
        check(fsm_out == 2'b00, "R5 reset out", fsm_out, 0);
        check(gate_cnt == '0, "R5 reset cnt", gate_cnt, 0);
        // IDLE self-loop, then start
        step(0, 0, 0); step(0, 0, 1); step(0, 0, 0);
        step(0, 1, 0);
        // ARM ignores halt and passes to RUN (R2)
        step(0, 0, 1);
        // RUN loops while start toggles (R1)
        step(0, 1, 0); step(0, 0, 0);
        step(0, 0, 1);           // to DRAIN
        step(0, 1, 0);           // back to RUN
        step(0, 0, 1);           // DRAIN
        step(0, 0, 0);           // IDLE
        // long IDLE hold to wrap the counter (R6)
        for (int i = 0; i < 14; i++) step(0, 0, 0);
        // reset in mid-run with self-loop inputs (R5)
        step(0, 1, 0); step(0, 0, 0); step(0, 0, 0);
        step(1, 0, 0);
        step(0, 0, 0);
        // R7: input change in high phase does not reach the enable
        @(negedge clk);
        @(posedge clk);
        #3;
        in_vec = 2'b01;
        #1;
        check(gclk_en == 1'b0, "R7 enable held in high phase", gclk_en, 0);
        @(negedge clk);
        #1;
        check(gclk_en == 1'b1, "R7 enable after fall", gclk_en, 1);
        rst = 1'b1;
        @(posedge clk);
        #2;
        done = 1;
    end

    initial begin
        for (int i = 0; i < 2000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) check(0, "watchdog", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule